// File: doc/BRIEF.md
# Fractional-Baud Asynchronous Serial Transmitter

This block turns parallel bytes into asynchronous serial characters on a single line that rests high. Each character has a low start bit, then 5 to 8 data bits sent least significant first, then an optional parity bit, then one high stop bit. A client hands over a byte with a valid/ready handshake. The line format, the parity mode and the baud divisor are static inputs. They must be held steady while a character is on the line.

Bit timing comes from a divisor in 16.6 fixed point: a 16-bit whole part and a 6-bit fraction in units of 1/64. Each bit lasts sixteen oversample periods. A period normally lasts as many clocks as the whole part. A 6-bit accumulator adds the fraction once per period. In any period where that sum carries out, the period gets one extra clock, so over time the average rate matches the fractional divisor.

An enable input gates when new characters may start. Dropping it during a character lets that character finish first. Parity can be off, odd, even, or forced to a constant level.

Top module: `uart_tx_frac`

## Requirements
- R1: Out of reset, and whenever no character is in flight, `tx_out` is 1 and `tx_busy` is 0. In that state `in_ready` is 1 exactly when `enable` is 1 and `div_int` is nonzero.
- R2: A character is one start bit of 0, then the data bits, then the parity bit when enabled, then one stop bit of 1.
- R3: `word_len` selects the number of data bits: 0 selects 5, 1 selects 6, 2 selects 7 and 3 selects 8. Data bits go out least significant first. Bits of `in_data` above the selected length are not sent.
- R4: When `par_en`=1 and `par_stick`=0, the line carries a parity bit. With `par_even`=1 it makes the count of ones over data plus parity even. With `par_even`=0 it makes that count odd.
- R5: When `par_en`=1 and `par_stick`=1, the parity bit is a constant: 0 when `par_even`=1 and 1 when `par_even`=0.
- R6: When `par_en`=0, no parity bit is sent and the stop bit follows the last data bit directly.
- R7: Let D be `div_int`, F be `div_frac`, and let the accept edge be offset 0. Bit b of a character begins 16·b·D + floor(16·b·F/64) clocks after that edge. For a character of N bits, `tx_busy` stays high for exactly 16·N·D + floor(16·N·F/64) cycles.
- R8: A byte is taken on a clock edge where `in_valid` and `in_ready` are both 1. Right after that edge, `tx_busy` is 1, `in_ready` is 0 and `tx_out` is 0.
- R9: While `enable` is 0, no character starts. If `enable` drops while a character is in flight, that character still completes with its full length and content.
- R10: While `div_int` is 0, no character starts, even with `in_valid` and `enable` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows new characters to start |
| div_int | input | 16 | Whole part of the clocks per oversample period |
| div_frac | input | 6 | Fractional part of the divisor, in 1/64 |
| word_len | input | 2 | Data-bit count code (5 + value) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity, or the constant-level choice in stick mode |
| par_stick | input | 1 | Forces the parity bit to a constant |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be accepted this cycle |
| tx_out | output | 1 | Serial line |
| tx_busy | output | 1 | A character is in flight |

## Verification
The hard part to observe is the fractional stretching. A single extra clock lands only in periods where the accumulator wraps, so a bit can be off by one clock without being obviously wrong. The bench reaches these cases with random fractions, plus the extremes F=0, F=63, D=1 and a large D. For each bit it computes the expected boundaries from the floor formula and samples the line at the middle of the bit. It also checks the exact last busy cycle and the first idle cycle. Dropping `enable` partway through a character is driven at a chosen offset inside the frame. This shows that the character completes and that no new one starts afterwards.

// File: rtl/uart_tx_frac_pkg.sv
package uart_tx_frac_pkg;
  localparam int unsigned DATA_MAX  = 8;
  localparam int unsigned FRAME_MAX = DATA_MAX + 3;
  localparam int unsigned NBITS_W   = $clog2(FRAME_MAX + 1);

  function automatic int unsigned data_bits(input logic [1:0] wl);
    return 5 + int'(wl);
  endfunction

  // parity level placed on the line for the given data and mode
  function automatic logic parity_level(input logic [DATA_MAX-1:0] d,
                                        input logic [1:0] wl,
                                        input logic even_sel,
                                        input logic stick_sel);
    logic x;
    x = 1'b0;
    for (int i = 0; i < int'(DATA_MAX); i++)
      if (i < int'(data_bits(wl))) x = x ^ d[i];
    if (stick_sel) return ~even_sel;
    return even_sel ? x : ~x;
  endfunction

  // frame vector, bit 0 is sent first; unused upper bits are 1
  function automatic logic [FRAME_MAX-1:0] build_frame(input logic [DATA_MAX-1:0] d,
                                                       input logic [1:0] wl,
                                                       input logic pen,
                                                       input logic even_sel,
                                                       input logic stick_sel);
    logic [FRAME_MAX-1:0] f;
    int unsigned w;
    w = data_bits(wl);
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < int'(DATA_MAX); i++)
      if (i < int'(w)) f[1+i] = d[i];
    if (pen) f[1+w] = parity_level(d, wl, even_sel, stick_sel);
    return f;
  endfunction

  function automatic logic [NBITS_W-1:0] frame_bits(input logic [1:0] wl, input logic pen);
    return NBITS_W'(2 + data_bits(wl) + (pen ? 1 : 0));
  endfunction
endpackage

// File: rtl/uart_tx_frac_baud.sv
module uart_tx_frac_baud #(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick
);
  localparam int unsigned CNT_W = INT_W + 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;
  logic [CNT_W-1:0]  limit;

  // carry of this period's accumulation stretches this period by one clock
  assign sum   = {1'b0, acc_q} + {1'b0, div_frac};
  assign limit = {1'b0, div_int} - CNT_W'(1) + CNT_W'(sum[FRAC_W]);
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
      acc_q <= sum[FRAC_W-1:0];
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/uart_tx_frac_frame.sv
module uart_tx_frac_frame #(
  parameter int unsigned FRAME_W = 11,
  parameter int unsigned NB_W    = 4,
  parameter int unsigned OVS     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [NB_W-1:0]    nbits_in,
  output logic               line,
  output logic               busy,
  output logic               bit_end,
  output logic               frame_done
);
  localparam int unsigned OVS_W = $clog2(OVS);

  logic [FRAME_W-1:0] shreg_q;
  logic [NB_W-1:0]    left_q;
  logic [OVS_W-1:0]   ovs_q;
  logic               busy_q;

  assign bit_end    = busy_q && tick && (ovs_q == OVS_W'(OVS - 1));
  assign frame_done = bit_end && (left_q == NB_W'(1));
  assign line       = shreg_q[0];
  assign busy       = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '1;
      left_q  <= '0;
      ovs_q   <= '0;
      busy_q  <= 1'b0;
    end else if (load && !busy_q) begin
      shreg_q <= frame_in;
      left_q  <= nbits_in;
      ovs_q   <= '0;
      busy_q  <= 1'b1;
    end else if (busy_q) begin
      if (tick) ovs_q <= ovs_q + OVS_W'(1);
      if (bit_end) begin
        shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
        left_q  <= left_q - NB_W'(1);
        if (frame_done) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_tx_frac.sv
module uart_tx_frac
  import uart_tx_frac_pkg::*;
#(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 6,
  parameter int unsigned OVS    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [INT_W-1:0]    div_int,
  input  logic [FRAC_W-1:0]   div_frac,
  input  logic [1:0]          word_len,
  input  logic                par_en,
  input  logic                par_even,
  input  logic                par_stick,
  input  logic [DATA_MAX-1:0] in_data,
  input  logic                in_valid,
  output logic                in_ready,
  output logic                tx_out,
  output logic                tx_busy
);
  logic                 tick;
  logic                 bit_end;
  logic                 frame_done;
  logic                 accept;
  logic [FRAME_MAX-1:0] frame_vec;
  logic [NBITS_W-1:0]   nbits;

  assign in_ready  = !tx_busy && enable && (div_int != '0);
  assign accept    = in_valid && in_ready;
  assign frame_vec = build_frame(in_data, word_len, par_en, par_even, par_stick);
  assign nbits     = frame_bits(word_len, par_en);

  uart_tx_frac_baud #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_baud (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (tx_busy),
    .div_int  (div_int),
    .div_frac (div_frac),
    .tick     (tick)
  );

  uart_tx_frac_frame #(.FRAME_W(FRAME_MAX), .NB_W(NBITS_W), .OVS(OVS)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .load       (accept),
    .frame_in   (frame_vec),
    .nbits_in   (nbits),
    .line       (tx_out),
    .busy       (tx_busy),
    .bit_end    (bit_end),
    .frame_done (frame_done)
  );
endmodule

// File: rtl/uart_tx_frac_chk.sv
module uart_tx_frac_chk #(
  parameter int unsigned INT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [INT_W-1:0] div_int,
  input logic             in_ready,
  input logic             tx_out,
  input logic             tx_busy,
  input logic             tick,
  input logic             accept,
  input logic             frame_done
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_out);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !tx_out);

  assert_stop_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> tx_out);

  assert_tick_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_int > 1) |=> !tick);

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (tx_busy && !in_ready));

  assert_finish_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !frame_done) |=> tx_busy);

  assert_enable_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !enable) |=> !tx_busy);

  assert_div_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && div_int == '0) |=> !tx_busy);
endmodule

bind uart_tx_frac uart_tx_frac_chk #(.INT_W(INT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .div_int    (div_int),
  .in_ready   (in_ready),
  .tx_out     (tx_out),
  .tx_busy    (tx_busy),
  .tick       (tick),
  .accept     (accept),
  .frame_done (frame_done)
);

// File: tb/uart_tx_frac_tb.sv
module uart_tx_frac_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] div_int = 16'd0;
  logic [5:0]  div_frac = 6'd0;
  logic [1:0]  word_len = 2'd3;
  logic        par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_valid = 1'b0;
  logic        in_ready, tx_out, tx_busy;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_tx_frac u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_int(div_int), .div_frac(div_frac),
    .word_len(word_len), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready), .tx_out(tx_out),
    .tx_busy(tx_busy)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int bit_start(input int b, input int dv, input int fr);
    return 16 * b * dv + (16 * b * fr) / 64;
  endfunction

  task automatic run_frame(input logic [7:0] d, input logic [1:0] wl, input logic pe,
                           input logic pev, input logic pst, input int dv, input int fr,
                           input int drop_k);
    int w, nb, ones, total;
    int exp_b[11];
    string tag[11];
    w = 5 + int'(wl);
    ones = 0;
    exp_b[0] = 0; tag[0] = "R2 start";
    for (int i = 0; i < w; i++) begin
      exp_b[1+i] = int'(d[i]);
      tag[1+i] = "R3 data";
      ones += int'(d[i]);
    end
    nb = 1 + w;
    if (pe) begin
      if (pst) begin exp_b[nb] = pev ? 0 : 1; tag[nb] = "R5 stick parity"; end
      else begin exp_b[nb] = pev ? (ones % 2) : 1 - (ones % 2); tag[nb] = "R4 parity"; end
      nb++;
    end
    exp_b[nb] = 1; tag[nb] = pe ? "R2 stop" : "R6 stop after data";
    nb++;
    total = bit_start(nb, dv, fr);
    div_int = 16'(dv); div_frac = 6'(fr); word_len = wl;
    par_en = pe; par_even = pev; par_stick = pst; in_data = d;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    in_data = 8'($urandom);
    for (int k = 0; k <= total; k++) begin
      if (k == drop_k) enable = 1'b0;
      if (k == 0) begin
        check("R8 line low after accept", int'(tx_out), 0);
        check("R8 ready low after accept", int'(in_ready), 0);
      end
      for (int b = 0; b < nb; b++) begin
        int s0, s1;
        s0 = bit_start(b, dv, fr);
        s1 = bit_start(b + 1, dv, fr);
        if (k == s0 + (s1 - s0) / 2) check(tag[b], int'(tx_out), exp_b[b]);
      end
      if (k == total - 1) check(pe ? "R7 busy last cycle" : "R6 R7 busy last cycle", int'(tx_busy), 1);
      if (k == total) begin
        check(drop_k >= 0 ? "R9 frame completes" : "R7 busy drops", int'(tx_busy), 0);
        check("R1 line idle high", int'(tx_out), 1);
      end
      if (k < total) @(negedge clk);
    end
    enable = 1'b1;
  endtask

  task automatic hold_no_start(input string req);
    in_valid = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tx_busy || !tx_out) begin
        check(req, int'(tx_busy), 0);
        break;
      end
    end
    check(req, int'(tx_busy), 0);
    check(req, int'(tx_out), 1);
    check(req, int'(in_ready), 0);
    in_valid = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset busy", int'(tx_busy), 0);
    check("R1 reset line", int'(tx_out), 1);
    check("R1 ready low while disabled", int'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    enable = 1'b1; div_int = 16'd3;
    @(negedge clk);
    check("R1 ready when enabled", int'(in_ready), 1);

    // directed corners
    run_frame(8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1, 0, -1);
    run_frame(8'hFF, 2'd0, 1'b1, 1'b1, 1'b0, 1, 63, -1);
    run_frame(8'h3C, 2'd1, 1'b1, 1'b0, 1'b0, 2, 32, -1);
    run_frame(8'h00, 2'd2, 1'b1, 1'b1, 1'b1, 3, 1, -1);
    run_frame(8'h00, 2'd3, 1'b1, 1'b0, 1'b1, 2, 17, -1);
    run_frame(8'hE0, 2'd0, 1'b0, 1'b0, 1'b0, 40, 63, -1);

    // enable dropped mid-frame, then held low
    run_frame(8'h96, 2'd3, 1'b1, 1'b1, 1'b0, 2, 10, 150);
    enable = 1'b0;
    hold_no_start("R9 no start while disabled");
    enable = 1'b1;

    // zero divisor
    div_int = 16'd0;
    hold_no_start("R10 no start with zero divisor");

    // random frames
    for (int n = 0; n < 50; n++) begin
      logic [1:0] wl;
      logic pe, pev, pst;
      int dv, fr;
      wl = 2'($urandom_range(0, 3));
      pe = 1'($urandom); pev = 1'($urandom); pst = 1'($urandom);
      dv = $urandom_range(1, 5);
      fr = $urandom_range(0, 63);
      run_frame(8'($urandom), wl, pe, pev, pst, dv, fr, ($urandom_range(0, 3) == 0) ? 40 : -1);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule